// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Slave Model

This block is a synthesizable behavioural model of a small serial EEPROM that a host reaches over three wires: a select line, a serial clock and a serial data input. A fourth wire, serial data out, is tri-stated. The model samples these pins with a fast system clock. It detects a rising serial-clock edge as a change between two system-clock samples, so the host may stretch or pause the serial clock at will. The array holds 128 words of 16 bits by default. A parameter switches it to 256 bytes.

A transfer starts with a 1 start bit after any number of 0 bits. Two opcode bits follow, then the address, then the data if the instruction carries any. Seven instructions are decoded: read, write, erase, erase-all, write-all, enable-programming and disable-programming. Programming is self-timed by a cycle counter and needs no serial clock. It continues after the select line drops. When the host raises the select line again, it can poll ready or busy on the data-out pin.

The control FSM has four states:

- `ST_IDLE`: waits for the start bit. Status is shown from this state.
- `ST_SHIFT`: collects the opcode, address and data.
- `ST_READ`: drives the read word.
- `ST_HOLD`: the instruction is complete and the serial clock is ignored.

The FSM moves between them as follows:

- IDLE→SHIFT happens on an accepted start bit.
- SHIFT→READ happens on a complete read header.
- SHIFT→HOLD happens on a complete non-read instruction.
- READ→HOLD happens on the rising edge after the last data bit.
- Any state→IDLE happens when select is low.

Top module: `mw_eeprom`

## Requirements
- R1: While `cs` is high and no start bit has been taken, rising `sclk` edges that sample `di`=0 change nothing. The first rising edge that samples `di`=1 begins an instruction.
- R2: While `cs` is low, the control logic is held idle, `sclk` is ignored and `sdo_en` is 0. If `cs` drops before the last bit of an instruction, that instruction has no effect.
- R3: The opcode is the 2 bits after the start bit, MSB first: 10 read, 01 write, 11 erase, 00 extended. For the extended opcode, the top two address bits select the operation: 11 enable, 00 disable, 10 erase-all, 01 write-all.
- R4: With `WIDE_ORG`=1 the address is 7 bits and a data word is 16 bits. With `WIDE_ORG`=0 the address is 8 bits and a data word is 8 bits. Address and data are sent MSB first. An instruction executes on the rising `sclk` edge that samples its last bit.
- R5: A read drives `sdo_en`=1 with a 0 dummy bit after the edge that samples the last address bit. The word then follows MSB first, one bit per later rising `sclk` edge.
- R6: After an instruction completes, further `sclk` edges and `di` values are ignored until `cs` goes low. After a read, the next rising edge releases `sdo_en`.
- R7: The programming-enable latch is clear after reset. Enable sets it and disable clears it. While it is clear, write, erase, erase-all and write-all change nothing.
- R8: Erase sets the addressed word to all ones and write stores the shifted word. Erase-all sets every word to all ones and write-all stores the shifted word in every word.
- R9: An accepted programming instruction makes the block busy for `PROG_CYCLES` system clocks, whatever `cs` does. Start bits are not taken while busy.
- R10: After a programming instruction, a status flag is pending. While the flag is pending and `cs` is high in idle, `sdo_en`=1 and `sdo` is 0 while busy and 1 when ready. An accepted start bit clears the flag. `cs` low while not busy also clears it, so a cycle spent wholly with `cs` low leaves `sdo_en`=0.
- R11: After `rst_n` every word reads as all ones and `sdo_en` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the pins and times programming |
| rst_n | input | 1 | Active-low power-up reset |
| cs | input | 1 | Chip select, active high |
| sclk | input | 1 | Serial clock from the host |
| di | input | 1 | Serial data in |
| sdo | output | 1 | Serial data out value |
| sdo_en | output | 1 | Output enable for the tri-state data-out pad |

## Verification
The bench puts 0 bits ahead of the start bit. A model that took the first edge as the start would then read the wrong word. It drops select in the middle of a write and checks that the word is unchanged, which catches a decoder that acts early. It also clocks extra bits after a finished instruction and checks that nothing restarts. It polls status across all three cases: select raised during busy, start bits sent during busy, and select held low for the whole cycle. Each case exposes a different mistake: a wrong busy polarity, a new instruction taken mid-cycle, or status driven when it should stay off. A disabled write, and an erase after disable, must leave the old data in place.

// File: rtl/mw_pkg.sv
package mw_pkg;
    typedef enum logic [1:0] {ST_IDLE, ST_SHIFT, ST_READ, ST_HOLD} mw_state_e;

    localparam logic [1:0] OP_EXT   = 2'b00;
    localparam logic [1:0] OP_WRITE = 2'b01;
    localparam logic [1:0] OP_READ  = 2'b10;
    localparam logic [1:0] OP_ERASE = 2'b11;

    localparam logic [1:0] EX_LOCK  = 2'b00;
    localparam logic [1:0] EX_FILL  = 2'b01;
    localparam logic [1:0] EX_WIPE  = 2'b10;
    localparam logic [1:0] EX_OPEN  = 2'b11;
endpackage

// File: rtl/mw_sclk_edge.sv
module mw_sclk_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic cs,
    input  logic sclk,
    output logic rise
);
    logic sclk_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sclk_q <= 1'b0;
        else        sclk_q <= sclk;
    end

    // Edges seen while deselected are not edges for the slave.
    assign rise = cs & sclk & ~sclk_q;
endmodule

// File: rtl/mw_prog_timer.sv
module mw_prog_timer #(
    parameter int CYCLES = 2000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy
);
    localparam int CW = $clog2(CYCLES + 1);
    logic [CW-1:0] left;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          left <= '0;
        else if (start)      left <= CW'(CYCLES);
        else if (left != '0) left <= left - 1'b1;
    end

    assign busy = (left != '0);
endmodule

// File: rtl/mw_array.sv
module mw_array #(
    parameter int AW = 7,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_one,
    input  logic          wr_all,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;
    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '1;
        end else if (wr_all) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= wdata;
        end else if (wr_one) begin
            mem[waddr] <= wdata;
        end
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/mw_eeprom.sv
module mw_eeprom
    import mw_pkg::*;
#(
    parameter bit WIDE_ORG    = 1'b1,
    parameter int PROG_CYCLES = 2000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs,
    input  logic sclk,
    input  logic di,
    output logic sdo,
    output logic sdo_en
);
    localparam int AW    = WIDE_ORG ? 7 : 8;
    localparam int DW    = WIDE_ORG ? 16 : 8;
    localparam int HDR   = 2 + AW;
    localparam int FRAME = HDR + DW;
    localparam int CW    = $clog2(FRAME + 1);

    mw_state_e     state, state_nx;
    logic [CW-1:0] cnt;
    logic [FRAME-2:0] sr;
    logic [FRAME-1:0] sr_nx;
    logic [DW:0]   out_sr;
    logic          wel, arm, rise, busy;

    logic          hdr_done, dat_done, need_data, start_ok;
    logic [1:0]    hdr_op, hdr_ext, full_op, full_ext;
    logic [AW-1:0] hdr_addr, full_addr, waddr;
    logic [DW-1:0] full_data, wdata, rdata;
    logic          wr_one, wr_all, prog_start, wel_set, wel_clr, rd_load;

    mw_sclk_edge u_edge (.clk(clk), .rst_n(rst_n), .cs(cs), .sclk(sclk), .rise(rise));

    mw_prog_timer #(.CYCLES(PROG_CYCLES)) u_timer (
        .clk(clk), .rst_n(rst_n), .start(prog_start), .busy(busy)
    );

    mw_array #(.AW(AW), .DW(DW)) u_array (
        .clk(clk), .rst_n(rst_n), .wr_one(wr_one), .wr_all(wr_all),
        .waddr(waddr), .wdata(wdata), .raddr(hdr_addr), .rdata(rdata)
    );

    // Field views of the frame including the bit sampled on this edge.
    assign sr_nx     = {sr, di};
    assign hdr_op    = sr_nx[HDR-1 -: 2];
    assign hdr_addr  = sr_nx[AW-1:0];
    assign hdr_ext   = hdr_addr[AW-1 -: 2];
    assign full_op   = sr_nx[FRAME-1 -: 2];
    assign full_addr = sr_nx[DW +: AW];
    assign full_ext  = full_addr[AW-1 -: 2];
    assign full_data = sr_nx[DW-1:0];

    assign hdr_done  = (state == ST_SHIFT) && rise && (cnt == CW'(HDR - 1));
    assign dat_done  = (state == ST_SHIFT) && rise && (cnt == CW'(FRAME - 1));
    assign need_data = (hdr_op == OP_WRITE) || ((hdr_op == OP_EXT) && (hdr_ext == EX_FILL));
    assign start_ok  = (state == ST_IDLE) && rise && di && !busy;

    // Instruction decode
    always_comb begin
        wr_one  = 1'b0;
        wr_all  = 1'b0;
        waddr   = hdr_addr;
        wdata   = '1;
        wel_set = 1'b0;
        wel_clr = 1'b0;
        rd_load = 1'b0;
        if (hdr_done) begin
            unique case (hdr_op)
                OP_READ:  rd_load = 1'b1;
                OP_ERASE: wr_one  = wel;
                OP_WRITE: ;
                OP_EXT: begin
                    unique case (hdr_ext)
                        EX_OPEN: wel_set = 1'b1;
                        EX_LOCK: wel_clr = 1'b1;
                        EX_WIPE: wr_all  = wel;
                        EX_FILL: ;
                    endcase
                end
            endcase
        end else if (dat_done && wel) begin
            waddr = full_addr;
            wdata = full_data;
            if (full_op == OP_WRITE)                          wr_one = 1'b1;
            else if (full_op == OP_EXT && full_ext == EX_FILL) wr_all = 1'b1;
        end
    end
    assign prog_start = wr_one | wr_all;

    // Next state
    always_comb begin
        state_nx = state;
        if (!cs) begin
            state_nx = ST_IDLE;
        end else begin
            unique case (state)
                ST_IDLE:  if (start_ok) state_nx = ST_SHIFT;
                ST_SHIFT: begin
                    if (hdr_done) begin
                        if (hdr_op == OP_READ) state_nx = ST_READ;
                        else if (!need_data)   state_nx = ST_HOLD;
                    end else if (dat_done) begin
                        state_nx = ST_HOLD;
                    end
                end
                ST_READ:  if (rise && cnt == CW'(FRAME)) state_nx = ST_HOLD;
                ST_HOLD:  ;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // Datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt    <= '0;
            sr     <= '0;
            out_sr <= '1;
            wel    <= 1'b0;
            arm    <= 1'b0;
        end else begin
            if (!cs || state == ST_IDLE) begin
                cnt <= '0;
                sr  <= '0;
            end else if (rise && (state == ST_SHIFT || state == ST_READ)) begin
                cnt <= cnt + 1'b1;
                if (state == ST_SHIFT) sr <= sr_nx[FRAME-2:0];
            end

            if (rd_load)                          out_sr <= {1'b0, rdata};
            else if (state == ST_READ && rise)    out_sr <= {out_sr[DW-1:0], 1'b0};

            if (wel_set)      wel <= 1'b1;
            else if (wel_clr) wel <= 1'b0;

            if (prog_start)             arm <= 1'b1;
            else if (start_ok && cs)    arm <= 1'b0;
            else if (!cs && !busy)      arm <= 1'b0;
        end
    end

    // Outputs
    always_comb begin
        sdo_en = cs && ((state == ST_READ) || (state == ST_IDLE && arm));
        sdo    = (state == ST_READ) ? out_sr[DW] : !busy;
    end
endmodule

// File: rtl/mw_eeprom_chk.sv
module mw_eeprom_chk
    import mw_pkg::*;
(
    input logic      clk,
    input logic      rst_n,
    input logic      cs,
    input logic      sdo_en,
    input logic      prog_start,
    input logic      busy,
    input logic      wel,
    input mw_state_e st
);
    // R2
    cs_low_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cs |-> !sdo_en);

    // R2
    cs_low_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cs |=> (st != ST_SHIFT));

    // R9
    prog_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        prog_start |=> busy);

    // R7
    prog_needs_wel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        prog_start |-> wel);

    // R9
    busy_no_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_IDLE && busy) |=> (st != ST_SHIFT));
endmodule

bind mw_eeprom mw_eeprom_chk u_chk (
    .clk(clk), .rst_n(rst_n), .cs(cs), .sdo_en(sdo_en),
    .prog_start(prog_start), .busy(busy), .wel(wel), .st(state)
);

// File: tb/mw_eeprom_tb_top.sv
module mw_eeprom_tb_top;
    localparam int AW   = 7;
    localparam int DW   = 16;
    localparam int PROG = 120;

    localparam logic [2:0] K_WR = 3'd0, K_RD = 3'd1, K_ER = 3'd2, K_EN = 3'd3,
                           K_DS = 3'd4, K_ERAL = 3'd5, K_WRAL = 3'd6;

    typedef struct packed {
        logic [2:0]  kind;
        logic [7:0]  addr;
        logic [15:0] data;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 21;
    localparam vec_t VECS [NV] = '{
        '{K_EN,   8'd0,   16'h0000, 4'd7},  // R7 enable
        '{K_WR,   8'd5,   16'hA5C3, 4'd3},  // R3 write
        '{K_RD,   8'd5,   16'hA5C3, 4'd3},  // R3 read back
        '{K_WR,   8'd127, 16'h8001, 4'd4},  // R4 top address, edge bits
        '{K_RD,   8'd127, 16'h8001, 4'd4},  // R4
        '{K_RD,   8'd126, 16'hFFFF, 4'd4},  // R4 neighbour untouched
        '{K_ER,   8'd5,   16'h0000, 4'd8},  // R8 erase
        '{K_RD,   8'd5,   16'hFFFF, 4'd8},  // R8
        '{K_DS,   8'd0,   16'h0000, 4'd7},  // R7 disable
        '{K_WR,   8'd6,   16'h0000, 4'd7},  // R7 blocked write
        '{K_RD,   8'd6,   16'hFFFF, 4'd7},  // R7
        '{K_ER,   8'd127, 16'h0000, 4'd7},  // R7 blocked erase
        '{K_RD,   8'd127, 16'h8001, 4'd7},  // R7
        '{K_EN,   8'd0,   16'h0000, 4'd7},  // R7
        '{K_WRAL, 8'd0,   16'h5A5A, 4'd8},  // R8 write-all
        '{K_RD,   8'd0,   16'h5A5A, 4'd8},  // R8
        '{K_RD,   8'd77,  16'h5A5A, 4'd8},  // R8
        '{K_ERAL, 8'd0,   16'h0000, 4'd8},  // R8 erase-all
        '{K_RD,   8'd64,  16'hFFFF, 4'd8},  // R8
        '{K_WR,   8'd0,   16'h0001, 4'd3},  // R3
        '{K_RD,   8'd0,   16'h0001, 4'd3}   // R3
    };

    logic clk = 1'b0, rst_n = 1'b0, cs = 1'b0, sclk = 1'b0, di = 1'b0;
    logic sdo, sdo_en;
    int   n_chk = 0, n_err = 0;

    always #4 clk = ~clk;

    mw_eeprom #(.WIDE_ORG(1'b1), .PROG_CYCLES(PROG)) dut_i (
        .clk(clk), .rst_n(rst_n), .cs(cs), .sclk(sclk), .di(di),
        .sdo(sdo), .sdo_en(sdo_en)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic clk_bit(input logic b);
        @(negedge clk) di = b;
        @(negedge clk) sclk = 1'b1;
        repeat (3) @(negedge clk);
        sclk = 1'b0;
        @(negedge clk);
    endtask

    task automatic cs_up();
        @(negedge clk) cs = 1'b1;
        @(negedge clk);
    endtask

    task automatic cs_down();
        @(negedge clk) begin cs = 1'b0; di = 1'b0; end
        repeat (2) @(negedge clk);
    endtask

    task automatic send_hdr(input logic [1:0] op, input logic [AW-1:0] a);
        clk_bit(1'b1);
        clk_bit(op[1]);
        clk_bit(op[0]);
        for (int i = AW - 1; i >= 0; i--) clk_bit(a[i]);
    endtask

    task automatic send_data(input logic [DW-1:0] d);
        for (int i = DW - 1; i >= 0; i--) clk_bit(d[i]);
    endtask

    task automatic do_prog(input logic [2:0] kind, input logic [AW-1:0] a, input logic [DW-1:0] d);
        logic [1:0]    op;
        logic [AW-1:0] ad;
        bit            wd;
        wd = 1'b0;
        ad = a;
        case (kind)
            K_WR:    begin op = 2'b01; wd = 1'b1; end
            K_ER:    op = 2'b11;
            K_EN:    begin op = 2'b00; ad = {2'b11, {(AW-2){1'b0}}}; end
            K_DS:    begin op = 2'b00; ad = {2'b00, {(AW-2){1'b0}}}; end
            K_ERAL:  begin op = 2'b00; ad = {2'b10, {(AW-2){1'b0}}}; end
            default: begin op = 2'b00; ad = {2'b01, {(AW-2){1'b0}}}; wd = 1'b1; end
        endcase
        cs_up();
        send_hdr(op, ad);
        if (wd) send_data(d);
        cs_down();
        repeat (PROG + 10) @(negedge clk);
    endtask

    task automatic do_read(input logic [AW-1:0] a, input logic [DW-1:0] exp, input int pre, input string tag);
        logic [DW-1:0] v;
        v = '0;
        cs_up();
        for (int i = 0; i < pre; i++) clk_bit(1'b0);
        if (pre > 0) chk(sdo_en === 1'b0, "R1 zeros before start", 32'(sdo_en), 32'd0);
        send_hdr(2'b10, a);
        chk(sdo_en === 1'b1 && sdo === 1'b0, "R5 dummy bit", {30'd0, sdo_en, sdo}, 32'd2);
        for (int i = 0; i < DW; i++) begin
            clk_bit(1'b0);
            v = {v[DW-2:0], sdo};
        end
        chk(v === exp, tag, 32'(v), 32'(exp));
        clk_bit(1'b1);
        chk(sdo_en === 1'b0, "R6 released after read", 32'(sdo_en), 32'd0);
        cs_down();
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R11 reset state
        chk(sdo_en === 1'b0, "R11 sdo_en after reset", 32'(sdo_en), 32'd0);
        cs_up();
        chk(sdo_en === 1'b0, "R11 no status after reset", 32'(sdo_en), 32'd0);
        cs_down();
        do_read(7'd3, 16'hFFFF, 0, "R11 erased at reset");
        do_prog(K_WR, 7'd3, 16'h0000);
        do_read(7'd3, 16'hFFFF, 0, "R7 write ignored after reset");

        // Vector table
        for (int i = 0; i < NV; i++) begin
            if (VECS[i].kind == K_RD)
                do_read(VECS[i].addr[AW-1:0], VECS[i].data, 0,
                        $sformatf("R%0d table entry %0d", VECS[i].req, i));
            else
                do_prog(VECS[i].kind, VECS[i].addr[AW-1:0], VECS[i].data);
        end

        // R1 leading zeros before the start bit
        do_read(7'd0, 16'h0001, 6, "R1 read after leading zeros");

        // R2 sclk with cs low is ignored
        for (int i = 0; i < 12; i++) clk_bit(1'b1);
        chk(sdo_en === 1'b0, "R2 sclk ignored while deselected", 32'(sdo_en), 32'd0);
        do_read(7'd0, 16'h0001, 0, "R2 state intact after deselected clocks");

        // R2 abort mid-write
        cs_up();
        send_hdr(2'b01, 7'd9);
        for (int i = 0; i < 5; i++) clk_bit(1'b0);
        cs_down();
        repeat (PROG + 10) @(negedge clk);
        do_read(7'd9, 16'hFFFF, 0, "R2 aborted write no effect");

        // R6 extra clocks after a completed write
        cs_up();
        send_hdr(2'b01, 7'd10);
        send_data(16'h0BEE);
        for (int i = 0; i < 11; i++) clk_bit(1'b1);
        chk(sdo_en === 1'b0, "R6 hold ignores clocks", 32'(sdo_en), 32'd0);
        cs_down();
        repeat (PROG + 10) @(negedge clk);
        do_read(7'd10, 16'h0BEE, 0, "R6 extra clocks did not alter word");

        // R10 status polled during busy, then ready, then cleared by start bit
        cs_up();
        send_hdr(2'b01, 7'd20);
        send_data(16'h1357);
        cs_down();
        cs_up();
        chk(sdo_en === 1'b1 && sdo === 1'b0, "R10 busy shown", {30'd0, sdo_en, sdo}, 32'd2);
        repeat (PROG + 10) @(negedge clk);
        chk(sdo_en === 1'b1 && sdo === 1'b1, "R10 ready shown", {30'd0, sdo_en, sdo}, 32'd3);
        clk_bit(1'b1);
        chk(sdo_en === 1'b0, "R10 start bit clears status", 32'(sdo_en), 32'd0);
        cs_down();
        do_read(7'd20, 16'h1357, 0, "R9 programming finished after deselect");

        // R9 start bits ignored while busy
        cs_up();
        send_hdr(2'b01, 7'd21);
        send_data(16'h2468);
        cs_down();
        cs_up();
        clk_bit(1'b1);
        clk_bit(1'b1);
        clk_bit(1'b0);
        chk(sdo_en === 1'b1 && sdo === 1'b0, "R9 start ignored while busy", {30'd0, sdo_en, sdo}, 32'd2);
        repeat (PROG + 10) @(negedge clk);
        chk(sdo_en === 1'b1 && sdo === 1'b1, "R9 ready after self-timed cycle", {30'd0, sdo_en, sdo}, 32'd3);
        cs_down();
        do_read(7'd21, 16'h2468, 0, "R9 word after busy");

        // R10 select low for the whole cycle keeps data out released
        cs_up();
        send_hdr(2'b01, 7'd22);
        send_data(16'h0F0F);
        cs_down();
        repeat (PROG + 10) @(negedge clk);
        cs_up();
        chk(sdo_en === 1'b0, "R10 no status after unobserved cycle", 32'(sdo_en), 32'd0);
        cs_down();
        do_read(7'd22, 16'h0F0F, 0, "R8 write stored");

        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule